// File: doc/BRIEF.md
# Output Fault Latch and Shutdown Sequencer

This block watches the digitized output voltage of a regulator against its DAC target and decides when the output has gone badly wrong. It flags an overvoltage or an undervoltage, stores that fault in a sticky latch, and records which kind it was. It then steps the regulator down in a fixed order. First it asks the slew logic to ramp the DAC to the zero code. Once the DAC reports that it has reached zero, it parks the power stage with the low-side switch held on and the high-side switch held off.

The overvoltage limit depends on the mode. In forced-PWM mode it is a ratio above the live DAC target. In pulse-skipping mode it is a fixed code. The undervoltage check is a ratio below the target and is suspended while the slew sequencer is moving the target. A test-mode input turns off overvoltage detection only. Once set, the latch can be cleared in only two ways: a full assert-then-release cycle of the shutdown input, or a loss of the VCC-valid flag.

Top module: `fault_shutdown_ctrl`

## Requirements
- R1: During and after reset, `fault_latched`, `pgood_kill`, `ramp_zero_req`, `dl_force_on` and `dh_force_off` are 0 and `fault_kind` is 2'b00 (none).
- R2: With `skip_mode`=0, a cycle in which `vout_code*100 > dac_code*OV_PCT` (default 113) sets `fault_latched`, `pgood_kill` and `fault_kind`=2'b01 (overvoltage) at the next clock edge. Equality does not trip.
- R3: With `skip_mode`=1, overvoltage trips when `vout_code > SKIP_OV_CODE`, whatever the DAC target. Equality does not trip.
- R4: A cycle in which `vout_code*100 < dac_code*UV_PCT` (default 70) sets the latch with `fault_kind`=2'b10 (undervoltage) at the next edge. Equality does not trip.
- R5: While `slewing`=1, undervoltage is not detected, but overvoltage still is.
- R6: While `no_fault_test`=1, overvoltage is not detected, but undervoltage still is.
- R7: If both conditions hold in the same cycle, `fault_kind` records 2'b01 (overvoltage).
- R8: `ramp_zero_req` rises together with the latch. `dl_force_on` and `dh_force_off` stay 0 until `dac_at_zero` is sampled high after the ramp request. They rise together one edge after that sample, at the earliest two edges after the latch.
- R9: While latched, `fault_latched` and `fault_kind` hold their values even if the fault condition goes away or a different fault condition appears.
- R10: A latched fault clears at the first edge that samples `shutdown`=0 after `shutdown`=1 was sampled while latched. At that edge all outputs return to 0 and `fault_kind` returns to 2'b00.
- R11: Sampling `vcc_ok`=0 clears the latch and all outputs at that edge. They stay clear while `vcc_ok` is 0.
- R12: No fault is latched from a cycle in which `shutdown`=1 or `vcc_ok`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| vout_code | input | CODE_W | Measured output voltage code |
| dac_code | input | CODE_W | Present DAC target code |
| skip_mode | input | 1 | 1 = pulse-skipping (fixed OV limit), 0 = forced PWM (ratio OV limit) |
| slewing | input | 1 | Target transition in progress; blanks undervoltage |
| no_fault_test | input | 1 | Test mode; disables overvoltage detection |
| shutdown | input | 1 | Shutdown request, active high |
| vcc_ok | input | 1 | Supply valid; 0 clears and holds the latch clear |
| dac_at_zero | input | 1 | DAC has reached the zero code |
| fault_latched | output | 1 | Sticky fault latch |
| pgood_kill | output | 1 | Forces power-good low |
| ramp_zero_req | output | 1 | Request to ramp the DAC to zero |
| dl_force_on | output | 1 | Force the low-side driver on |
| dh_force_off | output | 1 | Force the high-side driver off |
| fault_kind | output | 2 | 00 none, 01 overvoltage, 10 undervoltage |

## Verification
The assertions assume synchronous, glitch-free inputs and that `dac_at_zero` is meaningful only after a ramp request. They also assume the latch can only be set from a cycle with `shutdown` low and `vcc_ok` high. The stimulus changes inputs only on falling clock edges. It drives every fault condition from a cleared state with the shutdown input low. Between table vectors it returns the block to that state with a one-cycle drop of `vcc_ok`. The bench overrides the pulse-skip limit to a low code, so that an overvoltage and an undervoltage can occur in the same cycle within the code range.

// File: rtl/fsd_pkg.sv
package fsd_pkg;

  typedef enum logic [1:0] {
    SEQ_RUN  = 2'd0,
    SEQ_RAMP = 2'd1,
    SEQ_WAIT = 2'd2,
    SEQ_OFF  = 2'd3
  } seq_state_t;

  typedef enum logic [1:0] {
    KIND_NONE = 2'b00,
    KIND_OV   = 2'b01,
    KIND_UV   = 2'b10
  } fault_kind_t;

  // meas is more than pct percent of ref
  function automatic logic above_ratio(input int unsigned meas,
                                       input int unsigned ref_code,
                                       input int unsigned pct);
    longint unsigned lhs;
    longint unsigned rhs;
    lhs = 64'(meas) * 64'd100;
    rhs = 64'(ref_code) * 64'(pct);
    return lhs > rhs;
  endfunction

  // meas is less than pct percent of ref
  function automatic logic below_ratio(input int unsigned meas,
                                       input int unsigned ref_code,
                                       input int unsigned pct);
    longint unsigned lhs;
    longint unsigned rhs;
    lhs = 64'(meas) * 64'd100;
    rhs = 64'(ref_code) * 64'(pct);
    return lhs < rhs;
  endfunction

endpackage

// File: rtl/fsd_detect.sv
module fsd_detect #(
  parameter int CODE_W       = 10,
  parameter int OV_PCT       = 113,
  parameter int UV_PCT       = 70,
  parameter int SKIP_OV_CODE = 800
) (
  input  logic [CODE_W-1:0] vout_code,
  input  logic [CODE_W-1:0] dac_code,
  input  logic              skip_mode,
  input  logic              slewing,
  input  logic              no_fault_test,
  input  logic              enable,
  output logic              ov_hit,
  output logic              uv_hit
);
  import fsd_pkg::*;

  localparam logic [CODE_W-1:0] SKIP_LIM = CODE_W'(SKIP_OV_CODE);

  logic ov_ratio;
  logic ov_fixed;
  logic uv_ratio;

  always_comb begin
    ov_ratio = above_ratio(32'(vout_code), 32'(dac_code), OV_PCT);
    ov_fixed = vout_code > SKIP_LIM;
    uv_ratio = below_ratio(32'(vout_code), 32'(dac_code), UV_PCT);
  end

  assign ov_hit = enable && !no_fault_test && (skip_mode ? ov_fixed : ov_ratio);
  assign uv_hit = enable && !slewing && uv_ratio;

endmodule

// File: rtl/fsd_sequencer.sv
module fsd_sequencer (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 fault_take,
  input  logic                 shutdown,
  input  logic                 vcc_ok,
  input  logic                 dac_at_zero,
  output fsd_pkg::seq_state_t  state,
  output logic                 clear_evt
);
  import fsd_pkg::*;

  seq_state_t state_q;
  seq_state_t state_d;
  logic       armed_q;

  // armed: shutdown seen high while the sequence is away from RUN
  assign clear_evt = !vcc_ok || ((state_q != SEQ_RUN) && armed_q && !shutdown);

  always_comb begin
    state_d = state_q;
    if (clear_evt) begin
      state_d = SEQ_RUN;
    end else begin
      case (state_q)
        SEQ_RUN:  if (fault_take) state_d = SEQ_RAMP;
        SEQ_RAMP: state_d = SEQ_WAIT;
        SEQ_WAIT: if (dac_at_zero) state_d = SEQ_OFF;
        SEQ_OFF:  state_d = SEQ_OFF;
        default:  state_d = SEQ_RUN;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= SEQ_RUN;
      armed_q <= 1'b0;
    end else begin
      state_q <= state_d;
      if (clear_evt || state_q == SEQ_RUN) armed_q <= 1'b0;
      else if (shutdown)                   armed_q <= 1'b1;
    end
  end

  assign state = state_q;

endmodule

// File: rtl/fsd_status.sv
module fsd_status (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        ov_hit,
  input  logic        uv_hit,
  input  logic        clear_evt,
  output logic        latched,
  output logic [1:0]  kind
);
  import fsd_pkg::*;

  fault_kind_t kind_q;
  logic        latched_q;

  always_ff @(posedge clk) begin
    if (!rst_n || clear_evt) begin
      latched_q <= 1'b0;
      kind_q    <= KIND_NONE;
    end else if (!latched_q && (ov_hit || uv_hit)) begin
      latched_q <= 1'b1;
      kind_q    <= ov_hit ? KIND_OV : KIND_UV;  // overvoltage wins a tie
    end
  end

  assign latched = latched_q;
  assign kind    = kind_q;

endmodule

// File: rtl/fault_shutdown_ctrl.sv
module fault_shutdown_ctrl #(
  parameter int CODE_W       = 10,
  parameter int OV_PCT       = 113,
  parameter int UV_PCT       = 70,
  parameter int SKIP_OV_CODE = 800
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CODE_W-1:0] vout_code,
  input  logic [CODE_W-1:0] dac_code,
  input  logic              skip_mode,
  input  logic              slewing,
  input  logic              no_fault_test,
  input  logic              shutdown,
  input  logic              vcc_ok,
  input  logic              dac_at_zero,
  output logic              fault_latched,
  output logic              pgood_kill,
  output logic              ramp_zero_req,
  output logic              dl_force_on,
  output logic              dh_force_off,
  output logic [1:0]        fault_kind
);
  import fsd_pkg::*;

  seq_state_t seq_state;
  logic       det_enable;
  logic       ov_hit;
  logic       uv_hit;
  logic       clear_evt;
  logic       fault_take;

  assign det_enable = vcc_ok && !shutdown && (seq_state == SEQ_RUN);
  assign fault_take = ov_hit || uv_hit;

  fsd_detect #(
    .CODE_W(CODE_W), .OV_PCT(OV_PCT), .UV_PCT(UV_PCT), .SKIP_OV_CODE(SKIP_OV_CODE)
  ) u_detect (
    .vout_code(vout_code), .dac_code(dac_code), .skip_mode(skip_mode),
    .slewing(slewing), .no_fault_test(no_fault_test), .enable(det_enable),
    .ov_hit(ov_hit), .uv_hit(uv_hit)
  );

  fsd_sequencer u_seq (
    .clk(clk), .rst_n(rst_n), .fault_take(fault_take), .shutdown(shutdown),
    .vcc_ok(vcc_ok), .dac_at_zero(dac_at_zero), .state(seq_state),
    .clear_evt(clear_evt)
  );

  fsd_status u_status (
    .clk(clk), .rst_n(rst_n), .ov_hit(ov_hit), .uv_hit(uv_hit),
    .clear_evt(clear_evt), .latched(fault_latched), .kind(fault_kind)
  );

  assign pgood_kill    = fault_latched;
  assign ramp_zero_req = (seq_state != SEQ_RUN);
  assign dl_force_on   = (seq_state == SEQ_OFF);
  assign dh_force_off  = (seq_state == SEQ_OFF);

endmodule

// File: rtl/fault_shutdown_ctrl_chk.sv
module fault_shutdown_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       slewing,
  input logic       no_fault_test,
  input logic       shutdown,
  input logic       vcc_ok,
  input logic       dac_at_zero,
  input logic       fault_latched,
  input logic       ramp_zero_req,
  input logic       dl_force_on,
  input logic       dh_force_off,
  input logic [1:0] fault_kind
);

  assert_latch_req_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ramp_zero_req == fault_latched);

  assert_drivers_pair_R8: assert property (@(posedge clk) disable iff (!rst_n)
    dl_force_on == dh_force_off);

  assert_park_after_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dl_force_on) |-> $past(dac_at_zero));

  assert_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (fault_latched && vcc_ok && shutdown) |=> fault_latched);

  assert_kind_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    fault_latched |=> (!fault_latched || $stable(fault_kind)));

  assert_kind_clear_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !fault_latched |-> fault_kind == 2'b00);

  assert_vcc_clear_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !vcc_ok |=> !fault_latched);

  assert_set_gate_R12: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fault_latched) |-> $past(vcc_ok && !shutdown));

  assert_uv_blank_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(fault_latched) && fault_kind == 2'b10) |-> !$past(slewing));

  assert_ov_off_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(fault_latched) && fault_kind == 2'b01) |-> !$past(no_fault_test));

  assert_kind_onehot_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(fault_kind));

endmodule

bind fault_shutdown_ctrl fault_shutdown_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .slewing(slewing), .no_fault_test(no_fault_test),
  .shutdown(shutdown), .vcc_ok(vcc_ok), .dac_at_zero(dac_at_zero),
  .fault_latched(fault_latched), .ramp_zero_req(ramp_zero_req),
  .dl_force_on(dl_force_on), .dh_force_off(dh_force_off), .fault_kind(fault_kind)
);

// File: tb/fault_shutdown_ctrl_tb_top.sv
module fault_shutdown_ctrl_tb_top;

  localparam int CW   = 10;
  localparam int SKIP = 200;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [CW-1:0] vout_code = 10'd400;
  logic [CW-1:0] dac_code = 10'd400;
  logic          skip_mode = 1'b0;
  logic          slewing = 1'b0;
  logic          no_fault_test = 1'b0;
  logic          shutdown = 1'b0;
  logic          vcc_ok = 1'b1;
  logic          dac_at_zero = 1'b0;
  logic          fault_latched, pgood_kill, ramp_zero_req, dl_force_on, dh_force_off;
  logic [1:0]    fault_kind;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  fault_shutdown_ctrl #(.CODE_W(CW), .SKIP_OV_CODE(SKIP)) dut_i (
    .clk(clk), .rst_n(rst_n), .vout_code(vout_code), .dac_code(dac_code),
    .skip_mode(skip_mode), .slewing(slewing), .no_fault_test(no_fault_test),
    .shutdown(shutdown), .vcc_ok(vcc_ok), .dac_at_zero(dac_at_zero),
    .fault_latched(fault_latched), .pgood_kill(pgood_kill),
    .ramp_zero_req(ramp_zero_req), .dl_force_on(dl_force_on),
    .dh_force_off(dh_force_off), .fault_kind(fault_kind)
  );

  typedef struct packed {
    logic [9:0] dac;
    logic [9:0] vout;
    logic       skip;
    logic       slew;
    logic       nof;
    logic [1:0] kind;
    logic [3:0] req;
  } vec_t;

  localparam int NV = 15;
  localparam vec_t VECS [NV] = '{
    '{10'd400, 10'd452, 1'b0, 1'b0, 1'b0, 2'd0, 4'd2},
    '{10'd400, 10'd453, 1'b0, 1'b0, 1'b0, 2'd1, 4'd2},
    '{10'd0,   10'd1,   1'b0, 1'b0, 1'b0, 2'd1, 4'd2},
    '{10'd0,   10'd0,   1'b0, 1'b0, 1'b0, 2'd0, 4'd2},
    '{10'd400, 10'd280, 1'b0, 1'b0, 1'b0, 2'd0, 4'd4},
    '{10'd400, 10'd279, 1'b0, 1'b0, 1'b0, 2'd2, 4'd4},
    '{10'd200, 10'd200, 1'b1, 1'b0, 1'b0, 2'd0, 4'd3},
    '{10'd200, 10'd201, 1'b1, 1'b0, 1'b0, 2'd1, 4'd3},
    '{10'd100, 10'd150, 1'b1, 1'b0, 1'b0, 2'd0, 4'd3},
    '{10'd400, 10'd279, 1'b0, 1'b1, 1'b0, 2'd0, 4'd5},
    '{10'd400, 10'd500, 1'b0, 1'b1, 1'b0, 2'd1, 4'd5},
    '{10'd400, 10'd453, 1'b0, 1'b0, 1'b1, 2'd0, 4'd6},
    '{10'd400, 10'd100, 1'b0, 1'b0, 1'b1, 2'd2, 4'd6},
    '{10'd200, 10'd900, 1'b1, 1'b0, 1'b1, 2'd0, 4'd6},
    '{10'd400, 10'd250, 1'b1, 1'b0, 1'b0, 2'd1, 4'd7}
  };

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic safe_inputs();
    vout_code = 10'd400; dac_code = 10'd400; skip_mode = 1'b0;
    slewing = 1'b0; no_fault_test = 1'b0; dac_at_zero = 1'b0;
  endtask

  task automatic vcc_drop();
    safe_inputs();
    vcc_ok = 1'b0;
    @(negedge clk);
    vcc_ok = 1'b1;
    @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 latch in reset", int'(fault_latched), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 latch", int'(fault_latched), 0);
    chk("R1 pgood_kill", int'(pgood_kill), 0);
    chk("R1 ramp", int'(ramp_zero_req), 0);
    chk("R1 drivers", int'({dl_force_on, dh_force_off}), 0);
    chk("R1 kind", int'(fault_kind), 0);

    // table walk: R2 R3 R4 R5 R6 R7
    for (int i = 0; i < NV; i++) begin
      dac_code = VECS[i].dac; vout_code = VECS[i].vout;
      skip_mode = VECS[i].skip; slewing = VECS[i].slew;
      no_fault_test = VECS[i].nof;
      @(negedge clk);
      chk($sformatf("R%0d vec%0d kind", VECS[i].req, i), int'(fault_kind), int'(VECS[i].kind));
      chk($sformatf("R%0d vec%0d latch", VECS[i].req, i), int'(fault_latched), int'(VECS[i].kind != 0));
      chk($sformatf("R%0d vec%0d pgood_kill", VECS[i].req, i), int'(pgood_kill), int'(VECS[i].kind != 0));
      vcc_drop();
    end

    // R8 R9 R10: undervoltage, ramp, park, toggle clear
    vout_code = 10'd100;
    @(negedge clk);
    chk("R4 kind uv", int'(fault_kind), 2);
    chk("R8 ramp with latch", int'(ramp_zero_req), 1);
    chk("R8 drivers idle", int'(dl_force_on), 0);
    vout_code = 10'd400;
    repeat (3) @(negedge clk);
    chk("R8 no park without zero", int'({dl_force_on, dh_force_off}), 0);
    chk("R9 latch holds", int'(fault_latched), 1);
    vout_code = 10'd500;
    @(negedge clk);
    chk("R9 kind holds", int'(fault_kind), 2);
    dac_at_zero = 1'b1;
    @(negedge clk);
    chk("R8 park", int'({dl_force_on, dh_force_off}), 3);
    dac_at_zero = 1'b0;
    vout_code = 10'd400;
    shutdown = 1'b1;
    repeat (2) @(negedge clk);
    chk("R10 held while shutdown high", int'(fault_latched), 1);
    chk("R10 still parked", int'(dl_force_on), 1);
    shutdown = 1'b0;
    @(negedge clk);
    chk("R10 latch cleared", int'(fault_latched), 0);
    chk("R10 outputs cleared", int'({ramp_zero_req, dl_force_on, dh_force_off, pgood_kill}), 0);
    chk("R10 kind cleared", int'(fault_kind), 0);

    // R12: masked while shutdown high or vcc low
    shutdown = 1'b1; vout_code = 10'd100;
    repeat (2) @(negedge clk);
    chk("R12 no latch with shutdown", int'(fault_latched), 0);
    shutdown = 1'b0; vcc_ok = 1'b0;
    repeat (2) @(negedge clk);
    chk("R12 no latch with vcc low", int'(fault_latched), 0);
    vcc_ok = 1'b1; vout_code = 10'd400;
    @(negedge clk);
    chk("R12 clean after", int'(fault_latched), 0);

    // R11: vcc drop clears from a latched state
    vout_code = 10'd500;
    @(negedge clk);
    chk("R2 ov latch", int'(fault_kind), 1);
    vout_code = 10'd400; vcc_ok = 1'b0;
    @(negedge clk);
    chk("R11 cleared", int'(fault_latched), 0);
    chk("R11 kind cleared", int'(fault_kind), 0);
    vout_code = 10'd100;
    repeat (2) @(negedge clk);
    chk("R11 held clear", int'({fault_latched, ramp_zero_req}), 0);
    vcc_ok = 1'b1; vout_code = 10'd400;
    @(negedge clk);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule